// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Two-Entry Receive Queue

This block recovers characters from one asynchronous serial line. A one-cycle tick pulse that arrives sixteen times per bit period drives all of its timing. After a falling edge on the idle line, the block checks the start bit at its centre and drops a false start without raising any flag. It decides each data bit and the stop bit by a majority vote of three samples. A completed character goes into a two-entry queue together with its framing-error bit.

The consumer watches `data_avail`. It reads the head character on `rd_data` and its framing status on `frame_err`, then pulses `rd_pop` to remove that entry. A mode input selects a character length of 8 or 9 data bits. A polarity input can invert the line for low-true signalling. The receiver runs only when the port enable, the receive enable and the asynchronous-mode select are all high.

If a character completes while both queue entries are occupied, that character is lost and the `overrun` flag is raised. From then on no further character is accepted. Driving `rx_en` low clears the flag and returns the bit engine to idle, and the queue contents are kept.

Top module: `osr_uart_rx`

## Requirements
- R1: After reset, `data_avail`, `frame_err` and `overrun` are 0.
- R2: With `nine_bit`=0, 8 data bits are received least significant bit first. They appear on `rd_data[7:0]`, and `rd_data[8]` reads 0.
- R3: With `nine_bit`=1, a ninth data bit follows the first eight and appears on `rd_data[8]`.
- R4: A falling edge whose line has returned to 1 at tick 8 after the edge is abandoned. No character is stored and no error is flagged, and a later valid character is still received.
- R5: Each bit takes the majority of the samples at ticks 7, 8 and 9 of its bit period, counted from the detected start edge as tick 0. A wrong level at one of those ticks does not change the bit, and a wrong level at two of them does.
- R6: A stop bit voted 0 stores a framing error of 1 with that character, and a stop bit voted 1 stores 0. `frame_err` shows the flag of the head entry.
- R7: The queue holds two characters. A third character is accepted if one entry is popped before its stop bit is decided.
- R8: A pulse on `rd_pop` while `data_avail`=1 removes the oldest entry. A pulse on `rd_pop` on an empty queue has no effect.
- R9: A character that completes while the queue is full is dropped and sets `overrun`. While `overrun` is 1, no character is accepted, even after entries are popped.
- R10: `rx_en`=0 clears `overrun` and idles the bit engine, and the stored entries remain readable.
- R11: With `invert_rx`=1 the line is low-true: idle is 0, and data and stop bits are inverted at the pin.
- R12: Characters are received only while `port_en`, `rx_en` and `async_sel` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| port_en | input | 1 | Serial port enable |
| rx_en | input | 1 | Receive enable; low clears overrun |
| async_sel | input | 1 | 1 selects asynchronous operation |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| invert_rx | input | 1 | 1 inverts the received line |
| rx_pin | input | 1 | Serial input line |
| rd_pop | input | 1 | Removes the head queue entry |
| rd_data | output | 9 | Head character (0 when empty) |
| data_avail | output | 1 | Queue holds at least one entry |
| frame_err | output | 1 | Framing-error flag of the head entry |
| overrun | output | 1 | A character was dropped on a full queue |

## Verification
The assertions check the structural rules on every cycle. The queue fill never exceeds its depth. The bit engine stays idle while the receiver is disabled or an overrun is pending. The overrun flag is sticky until the receive enable drops. `data_avail` only falls after a pop. Whether the right bits land in the right entry can only be shown by the bench's scenarios: bit order, majority voting with glitches at chosen ticks, rejection of a false start, polarity inversion, framing status per entry, and a third character accepted or dropped depending on when a pop happens.

// File: rtl/osr_uart_rx_pkg.sv
package osr_uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/osr_rx_frontend.sv
// Line conditioning: synchronizer chain, polarity select, tick-sampled history.
module osr_rx_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_pin,
  input  logic invert,
  output logic lvl,
  output logic lvl_prev
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= rx_pin;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign lvl = sync_q[SYNC_STAGES-1] ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else if (tick) prev_q <= lvl;
  end

  assign lvl_prev = prev_q;
endmodule

// File: rtl/osr_rx_bitengine.sv
// Start validation, per-bit majority vote, character assembly, stop check.
module osr_rx_bitengine
  import osr_uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              hold,
  input  logic              nine_bit,
  input  logic              lvl,
  input  logic              lvl_prev,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              push_ferr,
  output logic              busy
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DATA_W + 1);
  localparam int MID = OSR / 2;
  localparam logic [CW-1:0] C_LO  = CW'(MID - 1);
  localparam logic [CW-1:0] C_MID = CW'(MID);
  localparam logic [CW-1:0] C_HI  = CW'(MID + 1);
  localparam logic [CW-1:0] C_END = CW'(OSR - 1);

  rx_state_e         state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BW-1:0]     bits_q, bits_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sa_q, sa_d, sb_q, sb_d;
  logic              vote;
  logic [BW-1:0]     last_bit;

  assign vote     = (sa_q & sb_q) | (sa_q & lvl) | (sb_q & lvl);
  assign last_bit = nine_bit ? BW'(DATA_W) : BW'(DATA_W - 1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bits_d  = bits_q;
    sh_d    = sh_q;
    sa_d    = sa_q;
    sb_d    = sb_q;
    push    = 1'b0;
    if (!run) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        RX_IDLE: begin
          if (!hold && lvl_prev && !lvl) begin
            state_d = RX_START;
            cnt_d   = CW'(1);
          end
        end
        RX_START: begin
          if (cnt_q == C_MID && lvl) begin
            state_d = RX_IDLE;
            cnt_d   = '0;
          end else if (cnt_q == C_END) begin
            state_d = RX_DATA;
            cnt_d   = '0;
            bits_d  = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == C_LO)  sa_d = lvl;
          if (cnt_q == C_MID) sb_d = lvl;
          if (cnt_q == C_HI && state_q == RX_DATA) begin
            sh_d   = {vote, sh_q[DATA_W-1:1]};
            bits_d = bits_q + 1'b1;
          end
          if (cnt_q == C_HI && state_q == RX_STOP) begin
            push    = 1'b1;
            state_d = RX_IDLE;
            cnt_d   = '0;
          end else if (cnt_q == C_END) begin
            cnt_d = '0;
            if (bits_q == last_bit) state_d = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bits_q  <= '0;
      sh_q    <= '0;
      sa_q    <= 1'b0;
      sb_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bits_q  <= bits_d;
      sh_q    <= sh_d;
      sa_q    <= sa_d;
      sb_q    <= sb_d;
    end
  end

  assign push_data = nine_bit ? sh_q : {1'b0, sh_q[DATA_W-1:1]};
  assign push_ferr = ~vote;
  assign busy      = (state_q != RX_IDLE);

  // R4: an abandoned start never leads to a push on the following cycle
  assert_false_start_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && state_d == RX_IDLE) |=> !push);
endmodule

// File: rtl/osr_rx_fifo.sv
// Receive queue holding {framing error, data}; sticky overrun on a full push.
module osr_rx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_word,
  input  logic         pop,
  input  logic         clr_ovr,
  output logic [W-1:0] head_word,
  output logic         not_empty,
  output logic         ovr
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem_q [DEPTH];
  logic [PW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            ovr_q, ovr_d;
  logic            full, empty, do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNTW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_d  = do_push ? ptr_inc(wr_q) : wr_q;
    rd_d  = do_pop ? ptr_inc(rd_q) : rd_q;
    unique case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    if (clr_ovr)          ovr_d = 1'b0;
    else if (push && full) ovr_d = 1'b1;
    else                   ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_word;
  end

  assign head_word = empty ? '0 : mem_q[rd_q];
  assign not_empty = !empty;
  assign ovr       = ovr_q;

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(DEPTH));
  assert_last_pop_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q == CNTW'(1)) |=> !not_empty);
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_ovr) |=> ovr_q);
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx #(
  parameter int OSR         = 16,
  parameter int DATA_W      = 9,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              port_en,
  input  logic              rx_en,
  input  logic              async_sel,
  input  logic              nine_bit,
  input  logic              invert_rx,
  input  logic              rx_pin,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_avail,
  output logic              frame_err,
  output logic              overrun
);
  localparam int ENTRY_W = DATA_W + 1;

  logic              lvl, lvl_prev, running;
  logic              eng_push, eng_ferr, eng_busy;
  logic [DATA_W-1:0] eng_data;
  logic [ENTRY_W-1:0] head;

  assign running = port_en & rx_en & async_sel;

  osr_rx_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rx_pin(rx_pin),
    .invert(invert_rx), .lvl(lvl), .lvl_prev(lvl_prev)
  );

  osr_rx_bitengine #(.OSR(OSR), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .run(running), .hold(overrun),
    .nine_bit(nine_bit), .lvl(lvl), .lvl_prev(lvl_prev), .push(eng_push),
    .push_data(eng_data), .push_ferr(eng_ferr), .busy(eng_busy)
  );

  osr_rx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(eng_push), .push_word({eng_ferr, eng_data}),
    .pop(rd_pop), .clr_ovr(!rx_en), .head_word(head), .not_empty(data_avail),
    .ovr(overrun)
  );

  assign rd_data   = head[DATA_W-1:0];
  assign frame_err = head[DATA_W];

  assert_halt_on_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !eng_busy);
  assert_gated_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !eng_busy);
  assert_clear_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun);
  assert_avail_fall_on_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_avail) |-> $past(rd_pop));
endmodule

// File: tb/osr_uart_rx_test.sv
module osr_uart_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div;
  logic       tick16;
  logic       port_en = 1'b1, rx_en = 1'b1, async_sel = 1'b1;
  logic       nine_bit = 1'b0, invert_rx = 1'b0, rx_pin = 1'b1, rd_pop = 1'b0;
  logic [8:0] rd_data;
  logic       data_avail, frame_err, overrun;
  logic       inv_b = 1'b0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) div <= 2'd0; else div <= div + 2'd1;
  assign tick16 = (div == 2'd3);

  osr_uart_rx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .port_en(port_en), .rx_en(rx_en),
    .async_sel(async_sel), .nine_bit(nine_bit), .invert_rx(invert_rx), .rx_pin(rx_pin),
    .rd_pop(rd_pop), .rd_data(rd_data), .data_avail(data_avail),
    .frame_err(frame_err), .overrun(overrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // one tick period at the given logical level
  task automatic tick_level(input logic lv);
    rx_pin = lv ^ inv_b;
    @(posedge clk);
    while (!tick16) @(posedge clk);
    #1;
  endtask

  function automatic logic [8:0] exp_word(input logic [8:0] d, input bit nine);
    return nine ? d : {1'b0, d[7:0]};
  endfunction

  task automatic send_frame(input logic [8:0] d, input bit nine, input bit stopv,
                            input int gbit, input int gfrom, input int glen);
    logic lv;
    for (int i = 0; i < 4; i++) tick_level(1'b1);
    for (int t = 0; t < 16; t++) tick_level(1'b0);
    for (int b = 0; b < (nine ? 9 : 8); b++)
      for (int t = 0; t < 16; t++) begin
        lv = d[b];
        if (b == gbit && t >= gfrom && t < gfrom + glen) lv = ~lv;
        tick_level(lv);
      end
    for (int t = 0; t < 16; t++) tick_level(stopv);
    for (int i = 0; i < 4; i++) tick_level(1'b1);
  endtask

  task automatic pop_check(input string req, input logic [8:0] expd, input bit expf);
    @(negedge clk);
    chk(req, "avail", int'(data_avail), 1);
    chk(req, "data", int'(rd_data), int'(expd));
    chk("R6", "frame_err", int'(frame_err), int'(expf));
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    chk(req, "avail", int'(data_avail), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [8:0] a, b, c, rd;
    bit nine, stopv;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "avail", int'(data_avail), 0);
    chk("R1", "overrun", int'(overrun), 0);
    chk("R1", "frame_err", int'(frame_err), 0);
    for (int i = 0; i < 8; i++) tick_level(1'b1);

    // R2 eight-bit LSB first
    send_frame(9'h0A5, 0, 1, -1, 0, 0);
    pop_check("R2", 9'h0A5, 0);
    expect_empty("R8");
    // R3 nine-bit
    nine_bit = 1'b1;
    send_frame(9'h1C3, 1, 1, -1, 0, 0);
    pop_check("R3", 9'h1C3, 0);
    nine_bit = 1'b0;

    // R4 false start
    for (int i = 0; i < 4; i++) tick_level(1'b1);
    for (int i = 0; i < 5; i++) tick_level(1'b0);
    for (int i = 0; i < 40; i++) tick_level(1'b1);
    @(negedge clk);
    chk("R4", "avail", int'(data_avail), 0);
    chk("R4", "frame_err", int'(frame_err), 0);
    send_frame(9'h03C, 0, 1, -1, 0, 0);
    pop_check("R4", 9'h03C, 0);

    // R5 majority vote: single wrong sample ignored, two flip the bit
    send_frame(9'h055, 0, 1, 2, 8, 1);
    pop_check("R5", 9'h055, 0);
    send_frame(9'h055, 0, 1, 3, 7, 1);
    pop_check("R5", 9'h055, 0);
    send_frame(9'h055, 0, 1, 4, 8, 2);
    pop_check("R5", 9'h045, 0);

    // R6 framing error stored per character
    send_frame(9'h0E1, 0, 0, -1, 0, 0);
    send_frame(9'h01E, 0, 1, -1, 0, 0);
    pop_check("R6", 9'h0E1, 1);
    pop_check("R6", 9'h01E, 0);

    // R11 inverted polarity
    @(negedge clk); rx_en = 1'b0; invert_rx = 1'b1; inv_b = 1'b1;
    for (int i = 0; i < 6; i++) tick_level(1'b1);
    @(negedge clk); rx_en = 1'b1;
    send_frame(9'h096, 0, 1, -1, 0, 0);
    pop_check("R11", 9'h096, 0);
    @(negedge clk); rx_en = 1'b0; invert_rx = 1'b0; inv_b = 1'b0;
    for (int i = 0; i < 6; i++) tick_level(1'b1);
    @(negedge clk); rx_en = 1'b1;

    // R12 enables gate reception
    @(negedge clk); async_sel = 1'b0;
    send_frame(9'h077, 0, 1, -1, 0, 0);
    expect_empty("R12");
    @(negedge clk); async_sel = 1'b1; port_en = 1'b0;
    send_frame(9'h077, 0, 1, -1, 0, 0);
    expect_empty("R12");
    @(negedge clk); rx_en = 1'b0; port_en = 1'b1;
    send_frame(9'h077, 0, 1, -1, 0, 0);
    expect_empty("R12");
    @(negedge clk); rx_en = 1'b1;

    // R7 third character accepted when a pop lands during its reception
    a = 9'h011; b = 9'h022; c = 9'h033;
    send_frame(a, 0, 1, -1, 0, 0);
    send_frame(b, 0, 1, -1, 0, 0);
    fork
      send_frame(c, 0, 1, -1, 0, 0);
      begin
        repeat (80 * 4) @(posedge clk);
        pop_check("R7", a, 0);
      end
    join
    @(negedge clk);
    chk("R7", "overrun", int'(overrun), 0);
    pop_check("R7", b, 0);
    pop_check("R7", c, 0);
    expect_empty("R7");

    // R9 overrun drops and blocks; R10 clear keeps contents
    send_frame(9'h0A1, 0, 1, -1, 0, 0);
    send_frame(9'h0A2, 0, 1, -1, 0, 0);
    send_frame(9'h0A3, 0, 1, -1, 0, 0);
    @(negedge clk);
    chk("R9", "overrun", int'(overrun), 1);
    pop_check("R9", 9'h0A1, 0);
    send_frame(9'h0A4, 0, 1, -1, 0, 0);
    pop_check("R9", 9'h0A2, 0);
    expect_empty("R9");
    chk("R9", "overrun", int'(overrun), 1);
    send_frame(9'h0A5, 0, 0, -1, 0, 0);
    expect_empty("R9");
    send_frame(9'h0B1, 0, 1, -1, 0, 0);
    expect_empty("R9");
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk);
    chk("R10", "overrun", int'(overrun), 1'b0);
    @(negedge clk); rx_en = 1'b1;
    send_frame(9'h0C1, 0, 1, -1, 0, 0);
    send_frame(9'h0C2, 0, 1, -1, 0, 0);
    send_frame(9'h0C3, 0, 1, -1, 0, 0);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk);
    chk("R10", "overrun", int'(overrun), 0);
    chk("R10", "avail", int'(data_avail), 1);
    rx_en = 1'b1;
    pop_check("R10", 9'h0C1, 0);
    pop_check("R10", 9'h0C2, 0);
    // R8 pop on empty has no effect
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
    expect_empty("R8");
    send_frame(9'h05A, 0, 1, -1, 0, 0);
    pop_check("R8", 9'h05A, 0);
    expect_empty("R8");

    // constrained random frames
    void'($urandom(32'd4242));
    for (int n = 0; n < 20; n++) begin
      rd = 9'($urandom);
      nine = 1'($urandom);
      stopv = (($urandom % 4) != 0);
      @(negedge clk); nine_bit = nine;
      send_frame(rd, nine, stopv, -1, 0, 0);
      if (nine) pop_check("R3", exp_word(rd, nine), !stopv);
      else      pop_check("R2", exp_word(rd, nine), !stopv);
    end
    expect_empty("R8");

    done = 1;
    summary();
  end
endmodule